// File: doc/BRIEF.md
# Phase Bisection Search

This block estimates a fringe phase without an arctangent. The phase range from -π to π is split into a fixed grid of nodes, with node k standing for θ = -π + 2π·k/NODES. Three node tables lie outside the block and share one read address. For each node they hold sin θ, cos θ, and an amplitude term (cos 2θ·S4 + sin 2θ·C4, where S4 and C4 are precomputed sums of the doubled-frequency sine and cosine). A pulse on the start pin latches the two correlation sums, Is and Ic, and the amplitude. The block then bisects the grid for a sign change of the optimality function.

The bisection takes a fixed number of steps, log2(NODES). One refinement step against the next node follows. The block then reports whichever of the two neighbouring nodes has its function value nearer zero. The result appears on the index output with a one-cycle done pulse. Converting the index to radians is left to the consumer. The worst-case quantization error is π/NODES.

Start, done and the table port are plain control and status pins. No valid/ready stream exists at the boundary. Operands are sampled only on an accepted start, so the block exerts no back-pressure.

Top module: `phase_bisect_search`

## Requirements
- R1: After reset, done_o is 0 and index_o is 0.
- R2: The function value at node b is v(b) = 2·(Is·cos[b] + Ic·sin[b]) − amp·A[b]. Table data must be presented on the table inputs in the cycle after the address appears on tbl_addr_o, which means the tables have a one-cycle registered read.
- R3: The search initialises with left = 0, step = NODES/2, right = step, and v_left = −2·Is − amp·A[0].
- R4: Each step evaluates v_right. Unless v_left < 0 and v_right ≥ 0, left takes right and v_left takes v_right. The step is then halved and right becomes left + step. The loop stops when the step reaches 0.
- R5: After the loop, if the same bracket test fails, right becomes left + 1 and v_right is read again at that node. Otherwise right becomes left + 1 and the old v_right is kept.
- R6: The result is left when |v_left| < v_right, and right otherwise.
- R7: The refinement node saturates at NODES − 1, so a search that never brackets a sign change returns NODES − 1.
- R8: done_o is high for exactly one cycle per search. index_o changes only together with done_o and holds between searches.
- R9: A start during a search is ignored. Is, Ic and amp are sampled only on an accepted start, and the running search yields one result from those values.
- R10: done_o rises exactly 2·NODE_BITS + 4 cycles after the start edge when the bracket holds after the loop, and 2·NODE_BITS + 6 cycles when the refinement re-reads a node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Search request, sampled when idle |
| is_i | input | DATA_W | Sine correlation sum Is (signed) |
| ic_i | input | DATA_W | Cosine correlation sum Ic (signed) |
| amp_i | input | DATA_W | Fringe amplitude (signed, non-negative) |
| tbl_addr_o | output | NODE_BITS | Node index read from all three tables |
| tbl_sin_i | input | TBL_W | sin θ of the addressed node, one cycle after the address |
| tbl_cos_i | input | TBL_W | cos θ of the addressed node, one cycle after the address |
| tbl_amp_i | input | TBL_W | Amplitude term of the addressed node, one cycle after the address |
| done_o | output | 1 | One-cycle result strobe |
| index_o | output | NODE_BITS | Selected phase node |

## Verification
The bench builds the block with NODE_BITS = 4 (16 nodes) and 16-bit operands and table words. At that size, every branch of the bisection can be steered node by node with hand-built tables. These include a bracket that holds to the end, a final step that forces the re-read, and a function that is negative everywhere and so drives the refinement node into saturation. Sinusoidal tables at the same size check the normal search against a model of the update rules. Exact latencies of 12 and 14 cycles separate the two end paths.

// File: rtl/psrch_pkg.sv
package psrch_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ0,
    ST_CALC0,
    ST_REQ,
    ST_CALC,
    ST_FIN,
    ST_REQF,
    ST_CALCF,
    ST_PICK
  } srch_state_t;
endpackage

// File: rtl/psrch_node_eval.sv
// Optimality function at one node: 2*(Is*cos + Ic*sin) - amp*A.
module psrch_node_eval #(
  parameter int DATA_W = 16,
  parameter int TBL_W  = 16,
  parameter int VAL_W  = DATA_W + TBL_W + 3
) (
  input  logic signed [DATA_W-1:0] is_i,
  input  logic signed [DATA_W-1:0] ic_i,
  input  logic signed [DATA_W-1:0] amp_i,
  input  logic signed [TBL_W-1:0]  sin_i,
  input  logic signed [TBL_W-1:0]  cos_i,
  input  logic signed [TBL_W-1:0]  amt_i,
  output logic signed [VAL_W-1:0]  val_o
);
  localparam int PROD_W = DATA_W + TBL_W;

  logic signed [PROD_W-1:0] p_cos, p_sin, p_amp;

  always_comb begin
    p_cos = is_i * cos_i;
    p_sin = ic_i * sin_i;
    p_amp = amp_i * amt_i;
    val_o = ((VAL_W'(p_cos) + VAL_W'(p_sin)) <<< 1) - VAL_W'(p_amp);
  end
endmodule

// File: rtl/psrch_idx_sat_add.sv
// Node index adder that clips at the last node.
module psrch_idx_sat_add #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] inc_i,
  output logic [IDX_W-1:0] sum_o
);
  logic [IDX_W:0] wide;

  always_comb begin
    wide  = {1'b0, base_i} + {1'b0, inc_i};
    sum_o = wide[IDX_W] ? {IDX_W{1'b1}} : wide[IDX_W-1:0];
  end
endmodule

// File: rtl/phase_bisect_search.sv
module phase_bisect_search
  import psrch_pkg::*;
#(
  parameter int NODE_BITS = 10,
  parameter int DATA_W    = 16,
  parameter int TBL_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic signed [DATA_W-1:0]    is_i,
  input  logic signed [DATA_W-1:0]    ic_i,
  input  logic signed [DATA_W-1:0]    amp_i,
  output logic        [NODE_BITS-1:0] tbl_addr_o,
  input  logic signed [TBL_W-1:0]     tbl_sin_i,
  input  logic signed [TBL_W-1:0]     tbl_cos_i,
  input  logic signed [TBL_W-1:0]     tbl_amp_i,
  output logic                        done_o,
  output logic        [NODE_BITS-1:0] index_o
);
  localparam int NODES = 1 << NODE_BITS;
  localparam int VAL_W = DATA_W + TBL_W + 3;
  localparam logic [NODE_BITS-1:0] HALF_SPAN = NODE_BITS'(NODES / 2);
  localparam logic [NODE_BITS-1:0] ONE_NODE  = NODE_BITS'(1);

  srch_state_t state_q;
  logic signed [DATA_W-1:0] is_q, ic_q, amp_q;
  logic [NODE_BITS-1:0] left_q, right_q, step_q, addr_q, idx_q;
  logic signed [VAL_W-1:0] vl_q, vr_q;
  logic done_q;
  logic busy;

  // Evaluator for the node just read, and the fixed start value.
  logic signed [VAL_W-1:0] v_cur, v_start;

  psrch_node_eval #(.DATA_W(DATA_W), .TBL_W(TBL_W), .VAL_W(VAL_W)) eval_node_i (
    .is_i(is_q), .ic_i(ic_q), .amp_i(amp_q),
    .sin_i(tbl_sin_i), .cos_i(tbl_cos_i), .amt_i(tbl_amp_i),
    .val_o(v_cur)
  );

  // cos = -1, sin = 0 yields -2*Is - amp*A[0].
  psrch_node_eval #(.DATA_W(DATA_W), .TBL_W(TBL_W), .VAL_W(VAL_W)) eval_start_i (
    .is_i(is_q), .ic_i(ic_q), .amp_i(amp_q),
    .sin_i('0), .cos_i({TBL_W{1'b1}}), .amt_i(tbl_amp_i),
    .val_o(v_start)
  );

  // Bracket tests and next-index arithmetic.
  logic                  brk_step, brk_end, pick_left;
  logic [NODE_BITS-1:0]  new_left, half_step, step_sum, nbr_sum;
  logic signed [VAL_W:0] abs_vl;

  always_comb begin
    brk_step  = (vl_q < 0) && (v_cur >= 0);
    brk_end   = (vl_q < 0) && (vr_q >= 0);
    new_left  = brk_step ? left_q : right_q;
    half_step = step_q >> 1;
    abs_vl    = (vl_q < 0) ? -(VAL_W+1)'(vl_q) : (VAL_W+1)'(vl_q);
    pick_left = abs_vl < (VAL_W+1)'(vr_q);
  end

  psrch_idx_sat_add #(.IDX_W(NODE_BITS)) add_step_i (
    .base_i(new_left), .inc_i(half_step), .sum_o(step_sum)
  );

  psrch_idx_sat_add #(.IDX_W(NODE_BITS)) add_nbr_i (
    .base_i(left_q), .inc_i(ONE_NODE), .sum_o(nbr_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_q    <= '0;
      ic_q    <= '0;
      amp_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      vl_q    <= '0;
      vr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          is_q    <= is_i;
          ic_q    <= ic_i;
          amp_q   <= amp_i;
          left_q  <= '0;
          step_q  <= HALF_SPAN;
          right_q <= HALF_SPAN;
          addr_q  <= '0;
          state_q <= ST_REQ0;
        end
        ST_REQ0:  state_q <= ST_CALC0;
        ST_CALC0: begin
          vl_q    <= v_start;
          addr_q  <= right_q;
          state_q <= ST_REQ;
        end
        ST_REQ:   state_q <= ST_CALC;
        ST_CALC: begin
          vr_q <= v_cur;
          if (!brk_step) begin
            left_q <= right_q;
            vl_q   <= v_cur;
          end
          step_q  <= half_step;
          right_q <= step_sum;
          if (half_step == '0) begin
            state_q <= ST_FIN;
          end else begin
            addr_q  <= step_sum;
            state_q <= ST_REQ;
          end
        end
        ST_FIN: begin
          right_q <= nbr_sum;
          if (brk_end) begin
            state_q <= ST_PICK;
          end else begin
            addr_q  <= nbr_sum;
            state_q <= ST_REQF;
          end
        end
        ST_REQF:  state_q <= ST_CALCF;
        ST_CALCF: begin
          vr_q    <= v_cur;
          state_q <= ST_PICK;
        end
        ST_PICK: begin
          idx_q   <= pick_left ? left_q : right_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign tbl_addr_o = addr_q;
  assign done_o     = done_q;
  assign index_o    = idx_q;
endmodule

// File: rtl/psrch_checker.sv
module psrch_checker #(
  parameter int NODE_BITS = 10,
  parameter int DATA_W    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic                        busy,
  input logic                        done_o,
  input logic        [NODE_BITS-1:0] index_o,
  input logic        [NODE_BITS-1:0] left_q,
  input logic        [NODE_BITS-1:0] right_q,
  input logic signed [DATA_W-1:0]    is_q
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_index_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(index_o));

  assert_operands_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(is_q));

  assert_neighbour_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((right_q == left_q) || (right_q == left_q + NODE_BITS'(1))));

  assert_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> busy);
endmodule

bind phase_bisect_search psrch_checker #(.NODE_BITS(NODE_BITS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
  .done_o(done_o), .index_o(index_o),
  .left_q(left_q), .right_q(right_q), .is_q(is_q)
);

// File: tb/phase_bisect_search_tb_top.sv
module phase_bisect_search_tb_top;
  localparam int NB_BITS = 4;
  localparam int NB      = 1 << NB_BITS;
  localparam int DW      = 16;
  localparam int TW      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [DW-1:0] is_d = '0, ic_d = '0, amp_d = '0;
  logic [NB_BITS-1:0] addr;
  logic signed [TW-1:0] rd_sin = '0, rd_cos = '0, rd_amt = '0;
  logic done;
  logic [NB_BITS-1:0] idx;

  int sin_t [NB];
  int cos_t [NB];
  int amt_t [NB];

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  phase_bisect_search #(.NODE_BITS(NB_BITS), .DATA_W(DW), .TBL_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .is_i(is_d), .ic_i(ic_d), .amp_i(amp_d),
    .tbl_addr_o(addr), .tbl_sin_i(rd_sin), .tbl_cos_i(rd_cos), .tbl_amp_i(rd_amt),
    .done_o(done), .index_o(idx)
  );

  // One-cycle registered table read (R2).
  always @(posedge clk) begin
    rd_sin <= TW'(sin_t[addr]);
    rd_cos <= TW'(cos_t[addr]);
    rd_amt <= TW'(amt_t[addr]);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint vf(longint s, longint c, longint a, int b);
    return 2 * (s * cos_t[b] + c * sin_t[b]) - a * amt_t[b];
  endfunction

  // Reference from the stated update rules; also gives the expected latency.
  task automatic model(input longint s, input longint c, input longint a,
                       output int e_idx, output int e_lat);
    int step = NB / 2;
    int l = 0;
    int r = step;
    longint vl = -2 * s - a * amt_t[0];
    longint vr = 0;
    longint avl;
    while (step >= 1) begin
      vr = vf(s, c, a, r);
      if (!(vl < 0 && vr >= 0)) begin vl = vr; l = r; end
      step = step / 2;
      r = l + step;
    end
    if (!(vl < 0 && vr >= 0)) begin
      r = (l + 1 > NB - 1) ? NB - 1 : l + 1;
      vr = vf(s, c, a, r);
      e_lat = 2 * NB_BITS + 6;
    end else begin
      r = (l + 1 > NB - 1) ? NB - 1 : l + 1;
      e_lat = 2 * NB_BITS + 4;
    end
    avl = (vl < 0) ? -vl : vl;
    e_idx = (avl < vr) ? l : r;
  endtask

  task automatic run_search(input int s, input int c, input int a,
                            input int e_idx, input int e_lat, input string req);
    int lat = 0;
    @(posedge clk); #1;
    is_d = DW'(s); ic_d = DW'(c); amp_d = DW'(a);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done && lat < 200) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(int'(idx) == e_idx, {req, " index"}, idx, e_idx);
    chk(lat == e_lat, {req, " R10 latency"}, lat, e_lat);
    @(posedge clk); #1;
    chk(done == 1'b0, {req, " R8 done one cycle"}, done, 0);
    chk(int'(idx) == e_idx, {req, " R8 index held"}, idx, e_idx);
  endtask

  task automatic load_ramp(input int zero_node, input int offs);
    for (int k = 0; k < NB; k++) begin
      sin_t[k] = 0;
      cos_t[k] = 100 * (k - zero_node) + offs;
      amt_t[k] = 0;
    end
  endtask

  task automatic test_reset();
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(idx == '0, "R1 index after reset", idx, 0);
  endtask

  // Bracket holds to the end; right neighbour nearer zero.
  task automatic test_bracket_right();
    load_ramp(9, 30);
    run_search(1, 0, 0, 9, 2 * NB_BITS + 4, "R4 R6 bracket right");
  endtask

  // Left neighbour nearer zero.
  task automatic test_bracket_left();
    load_ramp(9, 80);
    run_search(1, 0, 0, 8, 2 * NB_BITS + 4, "R6 pick left");
  endtask

  // Last step moves left, so the refinement re-reads node 10.
  task automatic test_refine_reread();
    load_ramp(9, -70);
    run_search(1, 0, 0, 10, 2 * NB_BITS + 6, "R5 refinement reread");
  endtask

  // Function negative everywhere: refinement node clips at NB-1.
  task automatic test_saturate();
    for (int k = 0; k < NB; k++) begin
      sin_t[k] = 0; cos_t[k] = 0; amt_t[k] = 5;
    end
    run_search(0, 0, 100, NB - 1, 2 * NB_BITS + 6, "R7 saturation");
  endtask

  // Sinusoidal tables with several operand sets against the model.
  task automatic test_sinusoid();
    int e_idx, e_lat;
    int s_set [4] = '{1200, -800, 300, -1500};
    int c_set [4] = '{-400, 900, 1500, -200};
    int a_set [4] = '{200, 350, 0, 600};
    for (int k = 0; k < NB; k++) begin
      real th;
      th = -3.14159265358979 + 2.0 * 3.14159265358979 * k / NB;
      sin_t[k] = $rtoi(1000.0 * $sin(th));
      cos_t[k] = $rtoi(1000.0 * $cos(th));
      amt_t[k] = $rtoi(1000.0 * ($cos(2.0 * th) * 3.2 + $sin(2.0 * th) * (-1.7)));
    end
    for (int t = 0; t < 4; t++) begin
      model(s_set[t], c_set[t], a_set[t], e_idx, e_lat);
      run_search(s_set[t], c_set[t], a_set[t], e_idx, e_lat, "R2 R3 sinusoid");
    end
  endtask

  // Second start and operand change mid-search are ignored.
  task automatic test_start_ignored();
    int lat = 0;
    int dones = 0;
    load_ramp(9, 30);
    @(posedge clk); #1;
    is_d = 16'sd1; ic_d = '0; amp_d = '0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (3) begin @(posedge clk); #1; lat++; end
    is_d = -16'sd500;
    start = 1'b1;
    @(posedge clk); #1;
    lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(posedge clk); #1; lat++; end
    chk(int'(idx) == 9, "R9 result from first operands", idx, 9);
    chk(lat == 2 * NB_BITS + 4, "R9 latency unchanged", lat, 2 * NB_BITS + 4);
    for (int w = 0; w < 30; w++) begin
      @(posedge clk); #1;
      if (done) dones++;
    end
    chk(dones == 0, "R9 no second search", dones, 0);
    chk(int'(idx) == 9, "R8 index held after idle", idx, 9);
  endtask

  initial begin
    for (int k = 0; k < NB; k++) begin sin_t[k] = 0; cos_t[k] = 0; amt_t[k] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    test_reset();
    test_bracket_right();
    test_bracket_left();
    test_refine_reread();
    test_saturate();
    test_sinusoid();
    test_start_ignored();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule